// File: doc/BRIEF.md
# Record Field Offset Allocator

This block lays out a record's scalar fields in memory the way a compiler does. Fields arrive one per handshake, in declaration order, each carrying a 2-bit size code. The block gives each field a byte offset that is a multiple of the field's own size. When the running end is not aligned, it puts the smallest possible gap of padding bytes in front of the field. It never changes the field order.

Each accepted field produces one result beat on a registered output stream. After the field flagged as last, the block emits one summary beat. That beat carries the record alignment, which is the size of the widest field. It also carries the tail padding and the total record size, which is rounded up to a multiple of that alignment. A sticky flag reports when the layout no longer fits in a 16-bit byte range. After the summary the accumulators clear, so the next record starts at offset zero.

Top module: `field_layout_engine`

## Requirements
- R1: Every accepted field yields exactly one field beat (out_is_summary = 0), and field beats leave in the order the fields were accepted.
- R2: The size code maps 2'b00 to 1 byte, 2'b01 to 2, 2'b10 to 4 and 2'b11 to 8. On a field beat, out_align is that size and out_offset is a multiple of it.
- R3: On a field beat, out_pad is the smallest gap (0 to size-1) that aligns the end of the previous field, which is 0 for the first field. out_total is the number of bytes used up to and including this field.
- R4: Consecutive 1-byte fields get consecutive offsets with out_pad = 0.
- R5: On the summary beat (out_is_summary = 1), out_align is the largest field size in the record, and out_offset is the end of the last field.
- R6: On the summary beat, out_pad is the tail padding and out_total is the smallest multiple of out_align that is not below the end of the last field.
- R7: From the cycle after the last field is accepted, in_ready stays low until the summary beat has been loaded into the output. The summary is loaded on the first cycle after the last field in which the output slot is free.
- R8: After a summary is issued, the next record starts at offset 0 with a fresh alignment.
- R9: out_overflow is high on any beat where the bytes used so far, or the padded total on the summary beat, exceed 65535. Once set, it stays set until the end of the record.
- R10: While out_valid is high and out_ready is low, every output holds its value.
- R11: During reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A field descriptor is offered |
| in_ready | output | 1 | The block accepts a field this cycle |
| in_size | input | 2 | Field size code |
| in_last | input | 1 | This field closes the record |
| out_valid | output | 1 | A result beat is held |
| out_ready | input | 1 | Sink takes the result beat |
| out_is_summary | output | 1 | 1 for the record summary, 0 for a field beat |
| out_offset | output | 16 | Field offset, or end of the last field on the summary |
| out_pad | output | 3 | Padding before the field, or tail padding |
| out_align | output | 4 | Alignment in bytes |
| out_total | output | 16 | Bytes used through this field, or padded record size |
| out_overflow | output | 1 | Layout exceeds the 16-bit byte range |

## Verification
The assertions assume that the sink never drops a beat it has not taken. They also assume that the offset checks are only meaningful while no overflow has occurred, so every offset and total property is qualified with the overflow flag being low. The stimulus drives in_size only with the four defined codes and moves in_valid and out_ready only between clock edges. It also runs one long record of 8-byte fields on purpose, so that the overflow path is reached while the alignment properties stay disabled.

// File: rtl/fle_pkg.sv
package fle_pkg;
  typedef enum logic [1:0] {
    FLE_SZ1 = 2'b00,
    FLE_SZ2 = 2'b01,
    FLE_SZ4 = 2'b10,
    FLE_SZ8 = 2'b11
  } fle_size_e;

  typedef enum logic {
    FLE_BEAT_FIELD   = 1'b0,
    FLE_BEAT_SUMMARY = 1'b1
  } fle_beat_e;
endpackage

// File: rtl/fle_align_calc.sv
module fle_align_calc #(
  parameter int OFFS_W = 16,
  parameter int LG_W   = 2,
  localparam int EXT_W = OFFS_W + 1,
  localparam int PAD_W = (2 ** LG_W) - 1
) (
  input  logic [EXT_W-1:0] cur_end,
  input  logic [LG_W-1:0]  size_lg,
  output logic [PAD_W-1:0] pad,
  output logic [EXT_W-1:0] start
);
  logic [EXT_W-1:0] mask;
  logic [EXT_W-1:0] gap;

  always_comb begin
    mask  = ({{(EXT_W-1){1'b0}}, 1'b1} << size_lg) - {{(EXT_W-1){1'b0}}, 1'b1};
    gap   = (~cur_end + {{(EXT_W-1){1'b0}}, 1'b1}) & mask;
    pad   = gap[PAD_W-1:0];
    start = cur_end + gap;
  end
endmodule

// File: rtl/fle_record_acc.sv
module fle_record_acc #(
  parameter int OFFS_W = 16,
  parameter int LG_W   = 2,
  localparam int EXT_W = OFFS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fld_take,
  input  logic             fld_last,
  input  logic [LG_W-1:0]  fld_lg,
  input  logic [EXT_W-1:0] fld_end,
  input  logic             sum_issue,
  output logic [EXT_W-1:0] cur_end,
  output logic [LG_W-1:0]  max_lg,
  output logic             ovf_q,
  output logic             sum_pend
);
  logic [EXT_W-1:0] end_d;
  logic [LG_W-1:0]  max_d;
  logic             ovf_d;
  logic             pend_d;
  logic             acc_en;

  always_comb begin
    acc_en = fld_take | sum_issue;
    end_d  = cur_end;
    max_d  = max_lg;
    ovf_d  = ovf_q;
    pend_d = sum_pend;
    if (sum_issue) begin
      end_d  = '0;
      max_d  = '0;
      ovf_d  = 1'b0;
      pend_d = 1'b0;
    end else if (fld_take) begin
      end_d  = fld_end;
      max_d  = (fld_lg > max_lg) ? fld_lg : max_lg;
      ovf_d  = ovf_q | fld_end[OFFS_W];
      pend_d = fld_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_end  <= '0;
      max_lg   <= '0;
      ovf_q    <= 1'b0;
      sum_pend <= 1'b0;
    end else if (acc_en) begin
      cur_end  <= end_d;
      max_lg   <= max_d;
      ovf_q    <= ovf_d;
      sum_pend <= pend_d;
    end
  end

  // R8: a record's state starts from zero after its summary
  a_r8_fresh_record: assert property (@(posedge clk) disable iff (!rst_n)
    sum_issue |=> (cur_end == '0) && (max_lg == '0) && !ovf_q);
endmodule

// File: rtl/fle_out_stage.sv
module fle_out_stage #(
  parameter int OFFS_W = 16,
  parameter int LG_W   = 2,
  localparam int PAD_W   = (2 ** LG_W) - 1,
  localparam int ALIGN_W = (2 ** LG_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               ld_is_sum,
  input  logic [OFFS_W-1:0]  ld_offset,
  input  logic [PAD_W-1:0]   ld_pad,
  input  logic [ALIGN_W-1:0] ld_align,
  input  logic [OFFS_W-1:0]  ld_total,
  input  logic               ld_ovf,
  input  logic               out_ready,
  output logic               slot_free,
  output logic               out_valid,
  output logic               out_is_summary,
  output logic [OFFS_W-1:0]  out_offset,
  output logic [PAD_W-1:0]   out_pad,
  output logic [ALIGN_W-1:0] out_align,
  output logic [OFFS_W-1:0]  out_total,
  output logic               out_overflow
);
  logic valid_d;

  always_comb begin
    slot_free = ~out_valid | out_ready;
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    else                valid_d = out_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_is_summary <= 1'b0;
      out_offset     <= '0;
      out_pad        <= '0;
      out_align      <= '0;
      out_total      <= '0;
      out_overflow   <= 1'b0;
    end else if (load) begin
      out_is_summary <= ld_is_sum;
      out_offset     <= ld_offset;
      out_pad        <= ld_pad;
      out_align      <= ld_align;
      out_total      <= ld_total;
      out_overflow   <= ld_ovf;
    end
  end

  // R10: a stalled beat keeps every field
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_offset) && $stable(out_total)
      && $stable(out_pad) && $stable(out_align) && $stable(out_is_summary));

  // R2: field offsets sit on their own size
  a_r2_offset_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_summary && !out_overflow) |->
      ((out_offset & (OFFS_W'(out_align) - 1'b1)) == '0));

  // R5: alignment is always a single power of two
  a_r5_align_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot(out_align));

  // R6: the padded total is a multiple of the record alignment
  a_r6_total_multiple: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_summary && !out_overflow) |->
      ((out_total & (OFFS_W'(out_align) - 1'b1)) == '0));
endmodule

// File: rtl/field_layout_engine.sv
module field_layout_engine #(
  parameter int OFFS_W = 16,
  parameter int LG_W   = 2,
  localparam int EXT_W   = OFFS_W + 1,
  localparam int PAD_W   = (2 ** LG_W) - 1,
  localparam int ALIGN_W = (2 ** LG_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LG_W-1:0]    in_size,
  input  logic               in_last,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_is_summary,
  output logic [OFFS_W-1:0]  out_offset,
  output logic [PAD_W-1:0]   out_pad,
  output logic [ALIGN_W-1:0] out_align,
  output logic [OFFS_W-1:0]  out_total,
  output logic               out_overflow
);
  import fle_pkg::*;

  logic               slot_free;
  logic               fld_take;
  logic               sum_issue;
  logic [EXT_W-1:0]   cur_end;
  logic [LG_W-1:0]    max_lg;
  logic               ovf_q;
  logic               sum_pend;
  logic [PAD_W-1:0]   fld_pad;
  logic [EXT_W-1:0]   fld_start;
  logic [EXT_W-1:0]   fld_end;
  logic [PAD_W-1:0]   tail_pad;
  logic [EXT_W-1:0]   rec_total;
  logic               ld_is_sum;
  logic [OFFS_W-1:0]  ld_offset;
  logic [PAD_W-1:0]   ld_pad;
  logic [ALIGN_W-1:0] ld_align;
  logic [OFFS_W-1:0]  ld_total;
  logic               ld_ovf;

  fle_align_calc #(.OFFS_W(OFFS_W), .LG_W(LG_W)) u_field_calc (
    .cur_end (cur_end),
    .size_lg (in_size),
    .pad     (fld_pad),
    .start   (fld_start)
  );

  fle_align_calc #(.OFFS_W(OFFS_W), .LG_W(LG_W)) u_tail_calc (
    .cur_end (cur_end),
    .size_lg (max_lg),
    .pad     (tail_pad),
    .start   (rec_total)
  );

  always_comb begin
    in_ready  = ~sum_pend & slot_free;
    fld_take  = in_valid & in_ready;
    sum_issue = sum_pend & slot_free;
    fld_end   = fld_start + (EXT_W'(1) << in_size);
    if (sum_pend) begin
      ld_is_sum = FLE_BEAT_SUMMARY;
      ld_offset = cur_end[OFFS_W-1:0];
      ld_pad    = tail_pad;
      ld_align  = ALIGN_W'(1) << max_lg;
      ld_total  = rec_total[OFFS_W-1:0];
      ld_ovf    = ovf_q | rec_total[OFFS_W];
    end else begin
      ld_is_sum = FLE_BEAT_FIELD;
      ld_offset = fld_start[OFFS_W-1:0];
      ld_pad    = fld_pad;
      ld_align  = ALIGN_W'(1) << in_size;
      ld_total  = fld_end[OFFS_W-1:0];
      ld_ovf    = ovf_q | fld_end[OFFS_W];
    end
  end

  fle_record_acc #(.OFFS_W(OFFS_W), .LG_W(LG_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .fld_take  (fld_take),
    .fld_last  (in_last),
    .fld_lg    (in_size),
    .fld_end   (fld_end),
    .sum_issue (sum_issue),
    .cur_end   (cur_end),
    .max_lg    (max_lg),
    .ovf_q     (ovf_q),
    .sum_pend  (sum_pend)
  );

  fle_out_stage #(.OFFS_W(OFFS_W), .LG_W(LG_W)) u_out (
    .clk            (clk),
    .rst_n          (rst_n),
    .load           (fld_take | sum_issue),
    .ld_is_sum      (ld_is_sum),
    .ld_offset      (ld_offset),
    .ld_pad         (ld_pad),
    .ld_align       (ld_align),
    .ld_total       (ld_total),
    .ld_ovf         (ld_ovf),
    .out_ready      (out_ready),
    .slot_free      (slot_free),
    .out_valid      (out_valid),
    .out_is_summary (out_is_summary),
    .out_offset     (out_offset),
    .out_pad        (out_pad),
    .out_align      (out_align),
    .out_total      (out_total),
    .out_overflow   (out_overflow)
  );

  // R7: taking the last field closes the input for the next cycle
  a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R1: each accepted field appears as a field beat on the next cycle
  a_r1_field_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && !out_is_summary));
endmodule

// File: tb/test_field_layout_engine.sv
module test_field_layout_engine;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic is_sum;
    int   off;
    int   pad;
    int   aln;
    int   tot;
    logic ovf;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_size = 2'b00;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_is_summary;
  logic [15:0] out_offset;
  logic [2:0]  out_pad;
  logic [3:0]  out_align;
  logic [15:0] out_total;
  logic        out_overflow;

  int   n_run = 0;
  int   n_fail = 0;
  int   rdy_mode = 0;
  int   codes[$];
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  field_layout_engine i_field_layout_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_size(in_size), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_is_summary(out_is_summary),
    .out_offset(out_offset), .out_pad(out_pad), .out_align(out_align),
    .out_total(out_total), .out_overflow(out_overflow)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // sink readiness pattern
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = cyc[0];
        default: out_ready = (cyc % 3 == 0);
      endcase
    end
  end

  // monitor: compare beats against the scoreboard
  initial begin
    logic held = 1'b0;
    logic [15:0] h_off = '0, h_tot = '0;
    forever begin
      @(negedge clk);
      if (rst_n && held) begin
        check("R10 held offset", out_offset, h_off);
        check("R10 held total", out_total, h_tot);
      end
      held = 1'b0;
      if (rst_n && out_valid && !out_ready) begin
        held = 1'b1; h_off = out_offset; h_tot = out_total;
      end
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check("R1 unexpected beat", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(e.is_sum ? "R5 summary kind" : "R1 field kind", out_is_summary, e.is_sum);
          check(e.is_sum ? "R5 data end" : "R2 offset", out_offset, e.off & 16'hFFFF);
          check(e.is_sum ? "R6 tail pad" : "R3 pad", out_pad, e.pad);
          check(e.is_sum ? "R5 record align" : "R2 field size", out_align, e.aln);
          check(e.is_sum ? "R6 total" : "R3 used bytes", out_total, e.tot & 16'hFFFF);
          check("R9 overflow", out_overflow, e.ovf);
        end
      end
    end
  end

  // driver: model the layout, push expectations, drive fields
  task automatic send_record();
    int e_end = 0, maxa = 1;
    logic ovf = 1'b0;
    foreach (codes[i]) begin
      exp_t x;
      int a, p, st;
      a  = 1 << codes[i];
      p  = (a - (e_end % a)) % a;
      st = e_end + p;
      e_end = st + a;
      if (a > maxa) maxa = a;
      if (e_end > 65535) ovf = 1'b1;
      x.is_sum = 1'b0; x.off = st; x.pad = p; x.aln = a; x.tot = e_end; x.ovf = ovf;
      expq.push_back(x);
    end
    begin
      exp_t s;
      int tail;
      tail = (maxa - (e_end % maxa)) % maxa;
      s.is_sum = 1'b1; s.off = e_end; s.pad = tail; s.aln = maxa;
      s.tot = e_end + tail; s.ovf = ovf | (e_end + tail > 65535);
      expq.push_back(s);
    end
    foreach (codes[i]) begin
      in_valid = 1'b1;
      in_size  = 2'(codes[i]);
      in_last  = (i == codes.size() - 1);
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    @(negedge clk);
    check("R7 ready low after last", in_ready, 0);
    while (expq.size() != 0) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset out_valid", out_valid, 0);
    check("R11 reset in_ready", in_ready, 1);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2 R3 byte, word, word, double
    codes = '{0, 2, 2, 3}; send_record();
    // R6 R8 word then two bytes: tail padding
    codes = '{2, 0, 0}; send_record();
    // R4 bytes pack tightly
    codes = '{0, 0, 0}; send_record();
    rdy_mode = 1;
    // R7 R10 with a slow sink
    codes = '{1, 0, 3, 0}; send_record();
    rdy_mode = 2;
    codes = '{3, 1, 0, 2, 0, 1}; send_record();
    codes = '{1}; send_record();
    rdy_mode = 0;
    // R9 overflow: 8192 doubles reach 65536 bytes
    codes = {};
    for (int k = 0; k < 8192; k++) codes.push_back(3);
    send_record();
    // R8 clean record after overflow
    codes = '{0, 3}; send_record();

    repeat (4) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule